// File: doc/BRIEF.md
# Reprogrammable Memory Command Interpreter

This block sits on the device side of a byte-wide reprogrammable memory. It watches the chip-enable and write-enable strobes from the host bus, sampled on a local clock. It turns each completed bus write into a mode change, and from the current mode it drives the array's program, erase and verify strobes. It also holds the address and data that those strobes act on. Writes take effect only while the high programming voltage is present and the supply is good. In every other condition the block sits in plain read mode.

A write is counted when chip enable and write enable are both low. The address is taken when that condition begins, and the data byte when it ends. Programming is a two-write sequence: a program set-up byte, then a write that carries the target address and data. The array program strobe runs from the end of that second write to the end of the next write. Bulk erase works the same way with two erase set-up bytes, and is normally closed by an erase-verify command that carries the address to check. The read path has an output-enable control and an identifier byte selector for use when the identifier voltage is present on the ninth address line.

Top module: `cmd_interp`

## Requirements
- R1: After reset the block is in read mode: all four array strobes are low.
- R2: While `hv_present` is low, writes are ignored and the block is forced to read mode from the next clock edge on.
- R3: While `supply_ok` is low, writes are ignored and the mode does not change.
- R4: A write starts on the first sampled cycle with `ce_n` and `we_n` both low, and it ends on the first sampled cycle where that no longer holds. The address is captured when the write starts. `arr_addr` takes it when the program data write or an erase-verify command (A0h) ends, and `arr_data` takes `din` when the program data write ends.
- R5: Code 40h enters program set-up. The next write ends with `arr_prog` high. `arr_prog` falls when the following write ends.
- R6: Code 20h enters erase set-up. A second 20h raises `arr_erase` when it ends, and `arr_erase` falls when the following write ends. If that write is A0h, `arr_everify` goes high.
- R7: In program set-up, an FFh write is taken as null program data (`arr_prog` high, `arr_data` = FFh). A second FFh returns the block to read mode.
- R8: In any mode other than program set-up, a single FFh (or 00h) returns the block to read mode.
- R9: Code C0h selects program verify (`arr_pverify` high), and `arr_addr` keeps the programmed address.
- R10: `dq_oe` is high only when both `ce_n` and `oe_n` are low.
- R11: With `id_volt` high and the outputs enabled, `id_en` is high. `id_byte` is the manufacturer byte when `addr[0]` = 0 and the device byte when it is 1. Each byte has odd parity, with bit 7 as the parity bit (defaults C2h and 43h).
- R12: Any other code returns the block to read mode. `arr_prog` and `arr_erase` never rise directly out of read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW (18) | Bus address |
| din | input | DW (8) | Bus write data |
| hv_present | input | 1 | High programming voltage present |
| id_volt | input | 1 | Identifier voltage present on address line 9 |
| supply_ok | input | 1 | Supply above write lockout threshold |
| arr_prog | output | 1 | Array program strobe |
| arr_erase | output | 1 | Array bulk erase strobe |
| arr_pverify | output | 1 | Program verify mode |
| arr_everify | output | 1 | Erase verify mode |
| arr_addr | output | AW | Latched array address |
| arr_data | output | DW | Latched program data |
| dq_oe | output | 1 | Data output drive enable |
| id_en | output | 1 | Identifier byte replaces array data |
| id_byte | output | DW | Selected identifier byte |

## Verification
The bench builds the block with its default widths: an 18-bit address, an 8-bit data byte, and the default 7-bit identifier codes. These widths let the lowest and highest addresses be used as program and erase-verify targets. They also let both identifier bytes be read back with their parity bit. The strobe-level bus protocol has no back-pressure. Every write is accepted or dropped on its own according to the voltage and supply flags, which the bench toggles in the middle of sequences.

// File: rtl/cmd_interp_pkg.sv
package cmd_interp_pkg;
  typedef enum logic [2:0] {
    M_READ, M_PSET, M_PROG, M_PVER, M_ESET, M_ERASE, M_EVER
  } mode_t;

  localparam logic [7:0] OP_READ = 8'h00;
  localparam logic [7:0] OP_PSET = 8'h40;
  localparam logic [7:0] OP_PVER = 8'hC0;
  localparam logic [7:0] OP_ESET = 8'h20;
  localparam logic [7:0] OP_EVER = 8'hA0;
  localparam logic [7:0] OP_RST  = 8'hFF;

  // plain command decode; anything unknown falls back to read
  function automatic mode_t decode_op(input logic [7:0] op);
    case (op)
      OP_PSET: return M_PSET;
      OP_PVER: return M_PVER;
      OP_ESET: return M_ESET;
      OP_EVER: return M_EVER;
      default: return M_READ;
    endcase
  endfunction
endpackage

// File: rtl/cmd_wr_edge.sv
module cmd_wr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic hv_present,
  input  logic supply_ok,
  output logic wr_start,
  output logic wr_end
);
  logic low_now, ok, low_q;

  assign low_now = ~ce_n & ~we_n;
  assign ok      = hv_present & supply_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b0;
    else        low_q <= low_now & ok;
  end

  assign wr_start = low_now & ok & ~low_q;
  assign wr_end   = low_q & ~low_now & ok;

  AST_START_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_start && wr_end)); // R4
  AST_END_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start); // R4
endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
  import cmd_interp_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_present,
  input  logic          wr_start,
  input  logic          wr_end,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output mode_t         mode,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_data
);
  localparam int OPW = (DW < 8) ? DW : 8;

  mode_t         mode_q, mode_d;
  logic [AW-1:0] addr_pend;
  logic [7:0]    op;
  logic          take_addr, take_data;

  assign op = 8'(din[OPW-1:0]);

  always_comb begin
    mode_d    = mode_q;
    take_addr = 1'b0;
    take_data = 1'b0;
    if (!hv_present) begin
      mode_d = M_READ;
    end else if (wr_end) begin
      case (mode_q)
        M_PSET: begin
          mode_d    = M_PROG;
          take_addr = 1'b1;
          take_data = 1'b1;
        end
        M_ESET:  mode_d = (op == OP_ESET) ? M_ERASE : decode_op(op);
        default: mode_d = decode_op(op);
      endcase
      if (mode_q != M_PSET && mode_d == M_EVER) take_addr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_READ;
      addr_pend <= '0;
      lat_addr  <= '0;
      lat_data  <= '1;
    end else begin
      mode_q <= mode_d;
      if (wr_start)  addr_pend <= addr;
      if (take_addr) lat_addr  <= addr_pend;
      if (take_data) lat_data  <= din;
    end
  end

  assign mode = mode_q;

  AST_HV_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_present |=> mode_q == M_READ); // R2
  AST_PROG_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_PROG && mode_d == M_PROG) |-> mode_q == M_PSET); // R5
  AST_ERASE_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_ERASE && mode_d == M_ERASE) |-> mode_q == M_ESET); // R6
  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == M_READ |=> (mode_q != M_PROG && mode_q != M_ERASE)); // R12
  AST_ADDR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_end |=> $stable(lat_addr)); // R4
endmodule

// File: rtl/cmd_id_out.sv
module cmd_id_out #(
  parameter int              DW     = 8,
  parameter logic [DW-2:0]   MFR_ID = 'h42,
  parameter logic [DW-2:0]   DEV_ID = 'h43
) (
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          id_volt,
  input  logic          sel,
  output logic          dq_oe,
  output logic          id_en,
  output logic [DW-1:0] id_byte
);
  localparam logic [DW-1:0] MFR_BYTE = {~^MFR_ID, MFR_ID};
  localparam logic [DW-1:0] DEV_BYTE = {~^DEV_ID, DEV_ID};

  assign dq_oe   = ~ce_n & ~oe_n;
  assign id_en   = dq_oe & id_volt;
  assign id_byte = id_en ? (sel ? DEV_BYTE : MFR_BYTE) : '0;

  always_comb begin
    if (id_en) begin
      AST_ID_ODD_PARITY: assert (^id_byte == 1'b1); // R11
    end
  end
endmodule

// File: rtl/cmd_interp.sv
module cmd_interp
  import cmd_interp_pkg::*;
#(
  parameter int            AW     = 18,
  parameter int            DW     = 8,
  parameter logic [DW-2:0] MFR_ID = 'h42,
  parameter logic [DW-2:0] DEV_ID = 'h43
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          hv_present,
  input  logic          id_volt,
  input  logic          supply_ok,
  output logic          arr_prog,
  output logic          arr_erase,
  output logic          arr_pverify,
  output logic          arr_everify,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data,
  output logic          dq_oe,
  output logic          id_en,
  output logic [DW-1:0] id_byte
);
  logic  wr_start, wr_end;
  mode_t mode;

  cmd_wr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .hv_present(hv_present), .supply_ok(supply_ok),
    .wr_start(wr_start), .wr_end(wr_end)
  );

  cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hv_present(hv_present),
    .wr_start(wr_start), .wr_end(wr_end), .addr(addr), .din(din),
    .mode(mode), .lat_addr(arr_addr), .lat_data(arr_data)
  );

  cmd_id_out #(.DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
    .ce_n(ce_n), .oe_n(oe_n), .id_volt(id_volt), .sel(addr[0]),
    .dq_oe(dq_oe), .id_en(id_en), .id_byte(id_byte)
  );

  assign arr_prog    = (mode == M_PROG);
  assign arr_erase   = (mode == M_ERASE);
  assign arr_pverify = (mode == M_PVER);
  assign arr_everify = (mode == M_EVER);

  AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && hv_present) |=> $stable(mode)); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({arr_prog, arr_erase, arr_pverify, arr_everify}) <= 1); // R1
endmodule

// File: tb/test_cmd_interp.sv
module test_cmd_interp;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic hv_present = 0, id_volt = 0, supply_ok = 1;
  logic arr_prog, arr_erase, arr_pverify, arr_everify, dq_oe, id_en;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data, id_byte;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_interp i_cmd_interp (.*);

  // behavioural reference: modes 0 read,1 pset,2 prog,3 pver,4 eset,5 erase,6 ever
  int m_mode = 0;
  bit m_low = 0;
  logic [AW-1:0] m_pend = '0, m_addr = '0;
  logic [DW-1:0] m_data = '1;

  function automatic int cmd_mode(input logic [7:0] c);
    if (c == 8'h40) return 1;
    if (c == 8'hC0) return 3;
    if (c == 8'h20) return 4;
    if (c == 8'hA0) return 6;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_low = 0; m_pend = '0; m_addr = '0; m_data = '1;
    end else begin
      bit lw, ok;
      lw = !ce_n && !we_n;
      ok = hv_present && supply_ok;
      if (lw && ok && !m_low) m_pend = addr;
      if (!hv_present) m_mode = 0;
      else if (m_low && !lw && ok) begin
        if (m_mode == 1) begin
          m_mode = 2; m_addr = m_pend; m_data = din;
        end else if (m_mode == 4 && din == 8'h20) m_mode = 5;
        else begin
          m_mode = cmd_mode(din);
          if (m_mode == 6) m_addr = m_pend;
        end
      end
      m_low = lw && ok;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] eid;
      eid = addr[0] ? 8'h43 : 8'hC2;
      chk("R5 model prog",     arr_prog,    m_mode == 2);
      chk("R6 model erase",    arr_erase,   m_mode == 5);
      chk("R9 model pverify",  arr_pverify, m_mode == 3);
      chk("R6 model everify",  arr_everify, m_mode == 6);
      chk("R4 model addr",     arr_addr,    m_addr);
      chk("R4 model data",     arr_data,    m_data);
      chk("R10 model oe",      dq_oe,       !ce_n && !oe_n);
      chk("R11 model id_en",   id_en,       !ce_n && !oe_n && id_volt);
      if (id_en) chk("R11 model id_byte", id_byte, eid);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; din = d; ce_n = 0; we_n = 0;
    tick(2);
    we_n = 1;
    tick(1);
    ce_n = 1;
    tick(1);
  endtask

  task automatic finish_up();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R1 reset prog",  arr_prog, 0);
    chk("R1 reset erase", arr_erase, 0);
    chk("R1 reset pver",  arr_pverify, 0);
    chk("R1 reset ever",  arr_everify, 0);
    chk("R10 ce high",    dq_oe, 0);

    // R2: no voltage, writes ignored
    wr('0, 8'h40); wr(18'h00011, 8'h22);
    chk("R2 hv low no prog", arr_prog, 0);

    hv_present = 1; tick(1);
    // R4/R5 program
    wr(18'h00000, 8'h40);
    chk("R5 setup no prog yet", arr_prog, 0);
    wr(18'h12345, 8'h5A);
    chk("R5 prog high", arr_prog, 1);
    chk("R4 addr", arr_addr, 18'h12345);
    chk("R4 data", arr_data, 8'h5A);
    wr(18'h00000, 8'hC0);
    chk("R5 prog ended", arr_prog, 0);
    chk("R9 pverify", arr_pverify, 1);
    chk("R9 addr kept", arr_addr, 18'h12345);
    ce_n = 0; oe_n = 0; tick(1);
    chk("R10 oe on", dq_oe, 1);
    oe_n = 1; tick(1);
    chk("R10 oe_n high", dq_oe, 0);
    ce_n = 1; tick(1);

    // R7 double reset
    wr('0, 8'h40);
    wr(18'h00007, 8'hFF);
    chk("R7 null prog", arr_prog, 1);
    chk("R7 null data", arr_data, 8'hFF);
    wr('0, 8'hFF);
    chk("R7 second ff read", arr_prog, 0);
    chk("R7 second ff no pver", arr_pverify, 0);

    // R6 erase
    wr('0, 8'h20);
    chk("R6 one 20h no erase", arr_erase, 0);
    wr('0, 8'h20);
    chk("R6 erase high", arr_erase, 1);
    wr(18'h3FFFF, 8'hA0);
    chk("R6 erase ended", arr_erase, 0);
    chk("R6 everify", arr_everify, 1);
    chk("R6 everify addr", arr_addr, 18'h3FFFF);

    // R8 single reset
    wr('0, 8'hFF);
    chk("R8 ff from everify", arr_everify, 0);
    wr('0, 8'h20); wr('0, 8'hFF); wr('0, 8'h20);
    chk("R8 ff cleared erase setup", arr_erase, 0);
    wr('0, 8'hFF);

    // R12 unknown code
    wr('0, 8'h55);
    chk("R12 unknown prog",  arr_prog, 0);
    chk("R12 unknown erase", arr_erase, 0);
    wr('0, 8'h20); wr('0, 8'h55); wr('0, 8'h20);
    chk("R12 unknown breaks erase pair", arr_erase, 0);
    wr('0, 8'h00);

    // R3 supply lockout
    supply_ok = 0;
    wr('0, 8'h40); wr(18'h00001, 8'h02);
    chk("R3 locked no prog", arr_prog, 0);
    supply_ok = 1; tick(1);
    wr('0, 8'h40); supply_ok = 0;
    wr(18'h00009, 8'h09); supply_ok = 1; tick(1);
    chk("R3 locked write dropped", arr_prog, 0);
    wr(18'h00009, 8'h33);
    chk("R3 setup survived", arr_prog, 1);

    // R2 voltage drop aborts
    hv_present = 0; tick(1);
    chk("R2 hv drop aborts", arr_prog, 0);
    wr('0, 8'h20); wr('0, 8'h20);
    chk("R2 hv low erase ignored", arr_erase, 0);
    hv_present = 1; tick(1);

    // R11 identifier
    id_volt = 1; ce_n = 0; oe_n = 0; addr = 18'h00000; tick(1);
    chk("R11 id_en", id_en, 1);
    chk("R11 mfr byte", id_byte, 8'hC2);
    addr = 18'h00001; tick(1);
    chk("R11 dev byte", id_byte, 8'h43);
    ce_n = 1; tick(1);
    chk("R10 ce high id off", dq_oe, 0);
    chk("R11 id off with ce high", id_en, 0);
    id_volt = 0; oe_n = 1; tick(2);
    finish_up();
  end
endmodule